// File: doc/BRIEF.md
# DMA Request Router with Synchronization Gate

This block sits between a set of peripheral request lines and the request inputs of a multi-channel DMA controller. Each DMA channel owns a control word that picks one of the peripheral request levels by number. In the plain mode the selected level goes straight to the channel output. In the gated mode the channel holds the request back until a programmed edge is seen on one of several synchronization inputs. It then opens a window in which a programmed number of requests may pass, counted on the DMA acknowledge.

A channel can also pulse an event output each time its programmed request count has been consumed. This output can be chained to other logic. An early synchronization edge, one that arrives while a window is still open, sets a per-channel overrun flag. The flags are grouped in one status word and cleared by writing ones to a clear word. Each channel can route its flag onto a shared interrupt line.

Software reaches the block through a single-cycle write port and a combinational read port. Each request is a level that stays high until the DMA acknowledges it.

Top module: `dreq_router`

## Requirements
- R1: With sync gating off and a nonzero control word, channel output `dma_req[c]` equals `req_in[sel]` in the same cycle, where `sel` is control bits [7:0]. A `sel` at or above the number of request inputs yields 0.
- R2: A channel whose control word is zero drives `dma_req[c]` low regardless of `req_in`. Writing the value zero to a control word clears every field of it (the request count included) and clears that channel's window, counter and event.
- R3: With the gate enable (control bit 16) set and no window open, `dma_req[c]` stays low even while the selected request is high. The gate input is picked by control bits [26:24].
- R4: Control bits [18:17] choose the gate edge: 0 never, 1 rising, 2 falling, 3 both. Only the chosen edge opens a window.
- R5: A qualifying edge seen at a clock edge opens the window from the next cycle. The window passes exactly N+1 acknowledged requests, where N is control bits [23:19], and then closes with `dma_req[c]` low until the next qualifying edge.
- R6: A nonzero write to a control word while its gate enable or event enable is currently set leaves field [23:19] at its old value. The other fields take the written value.
- R7: With the event enable (control bit 9) set, `dma_evt[c]` is high for one cycle, in the cycle after the acknowledge that consumes the (N+1)-th request. Without gating, acknowledges are counted in groups of N+1.
- R8: A qualifying edge that arrives while the channel's window is open sets bit c of the status word (address 8). The window and its count carry on unchanged.
- R9: Writing to the clear word (address 9) clears each status bit whose written bit is 1. Bits written as 0 keep their value.
- R10: `irq` is high when any channel has its status bit set together with its interrupt enable (control bit 8).
- R11: After reset all control words and status bits read 0, and `dma_req`, `dma_evt` and `irq` are low.
- R12: Reads are combinational: address c (below the channel count) returns control word c, address 8 returns the status word, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| req_in | input | NUM_REQ (64) | Peripheral request levels |
| sync_in | input | NUM_SYNC (8) | Gate trigger inputs |
| dma_ack | input | NUM_CH (7) | Per-channel DMA acknowledge |
| dma_req | output | NUM_CH (7) | Per-channel request to the DMA controller |
| dma_evt | output | NUM_CH (7) | Per-channel end-of-count event pulse |
| irq | output | 1 | Overrun interrupt |

## Verification
The assertions assume that an acknowledge is only given to a channel whose request is high. They also assume that the request-count field does not change behind the write lock. They take the gate inputs to be synchronous to the clock when the resynchronizer is left out. The stimulus drives every request, gate and acknowledge change on the falling clock edge, and pulses each acknowledge for exactly one cycle while the request is seen high. It programs each count while both enables are clear, so the assumed input discipline is never broken.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
   // control word layout
   localparam int unsigned CFG_W    = 32;
   localparam int unsigned SEL_W    = 8;
   localparam int unsigned B_OIE    = 8;
   localparam int unsigned B_EGE    = 9;
   localparam int unsigned B_SE     = 16;
   localparam int unsigned POL_LSB  = 17;
   localparam int unsigned NB_LSB   = 19;
   localparam int unsigned NB_W     = 5;
   localparam int unsigned SS_LSB   = 24;
   localparam int unsigned SS_W     = 3;
   localparam logic [CFG_W-1:0] NB_MASK = ((CFG_W'(1) << NB_W) - CFG_W'(1)) << NB_LSB;

   // register addresses beyond the per-channel words
   localparam int unsigned ADDR_STATUS = 8;
   localparam int unsigned ADDR_CLEAR  = 9;

   typedef enum logic [1:0] {
      POL_NONE = 2'd0,
      POL_RISE = 2'd1,
      POL_FALL = 2'd2,
      POL_BOTH = 2'd3
   } sync_pol_e;

   function automatic logic pol_match(sync_pol_e p, logic rise, logic fall);
      case (p)
         POL_RISE: return rise;
         POL_FALL: return fall;
         POL_BOTH: return rise | fall;
         default:  return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/dreq_regs.sv
module dreq_regs
   import dreq_pkg::*;
#(
   parameter int unsigned NUM_CH = 7,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [CFG_W-1:0]              wdata,
   output logic [CFG_W-1:0]              rdata,
   input  logic [NUM_CH-1:0]             ovr_set,
   output logic [NUM_CH-1:0][CFG_W-1:0]  ctrl_q,
   output logic [NUM_CH-1:0]             flags_q
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ADDR_CLEAR);

   if (NUM_CH > ADDR_STATUS || NUM_CH > CFG_W) begin : g_chk_ch
      $error("dreq_regs: NUM_CH collides with the status address");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit, locked;
      assign hit    = we && (addr == ADDR_W'(c));
      assign locked = ctrl_q[c][B_SE] | ctrl_q[c][B_EGE];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q[c] <= '0;
         end else if (hit) begin
            if (wdata == '0)
               ctrl_q[c] <= '0;
            else if (locked)
               ctrl_q[c] <= (wdata & ~NB_MASK) | (ctrl_q[c] & NB_MASK);
            else
               ctrl_q[c] <= wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags_q[c] <= 1'b0;
         else if (ovr_set[c])
            flags_q[c] <= 1'b1;
         else if (we && addr == A_CLR && wdata[c])
            flags_q[c] <= 1'b0;
      end

      assert_zero_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && wdata == '0) |=> (ctrl_q[c] == '0));
      assert_nb_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && wdata != '0 && locked) |=> ((ctrl_q[c] & NB_MASK) == ($past(ctrl_q[c]) & NB_MASK)));
      assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
         ovr_set[c] |=> flags_q[c]);
   end

   always_comb begin
      rdata = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (addr == ADDR_W'(c)) rdata = ctrl_q[c];
      if (addr == A_STAT) rdata = CFG_W'(flags_q);
   end
endmodule

// File: rtl/dreq_chan.sv
module dreq_chan
   import dreq_pkg::*;
#(
   parameter int unsigned NUM_REQ  = 64,
   parameter int unsigned NUM_SYNC = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CFG_W-1:0]     cfg_i,
   input  logic [NUM_REQ-1:0]   req_i,
   input  logic [NUM_SYNC-1:0]  sync_i,
   input  logic                 ack_i,
   output logic                 req_o,
   output logic                 evt_o,
   output logic                 ovr_o
);
   localparam int unsigned REQ_W  = $clog2(NUM_REQ);
   localparam int unsigned SYNC_W = $clog2(NUM_SYNC);

   logic [SEL_W-1:0] sel;
   logic [SS_W-1:0]  ssel;
   logic [NB_W-1:0]  nbreq, cnt_q;
   logic             cfg_on, gate_en, evt_en;
   sync_pol_e        pol;
   logic             req_pick, sync_pick, sync_q;
   logic             trig, open_q, take, last, evt_q;

   assign sel     = cfg_i[SEL_W-1:0];
   assign ssel    = cfg_i[SS_LSB +: SS_W];
   assign nbreq   = cfg_i[NB_LSB +: NB_W];
   assign pol     = sync_pol_e'(cfg_i[POL_LSB +: 2]);
   assign gate_en = cfg_i[B_SE];
   assign evt_en  = cfg_i[B_EGE];
   assign cfg_on  = |cfg_i;

   assign req_pick  = ({1'b0, sel} < (SEL_W+1)'(NUM_REQ))  ? req_i[sel[REQ_W-1:0]]   : 1'b0;
   assign sync_pick = ({1'b0, ssel} < (SS_W+1)'(NUM_SYNC)) ? sync_i[ssel[SYNC_W-1:0]] : 1'b0;

   assign trig  = gate_en & pol_match(pol, sync_pick & ~sync_q, ~sync_pick & sync_q);
   assign req_o = cfg_on & req_pick & (gate_en ? open_q : 1'b1);
   assign take  = req_o & ack_i;
   assign last  = take & (cnt_q == nbreq);
   assign ovr_o = trig & open_q;
   assign evt_o = evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 1'b0;
      else        sync_q <= sync_pick;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
         evt_q  <= 1'b0;
      end else if (!cfg_on) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
         evt_q  <= 1'b0;
      end else begin
         evt_q <= evt_en & last;
         if (gate_en) begin
            if (open_q) begin
               if (last) begin
                  open_q <= 1'b0;
                  cnt_q  <= '0;
               end else if (take) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else if (trig) begin
               open_q <= 1'b1;
               cnt_q  <= '0;
            end
         end else begin
            open_q <= 1'b0;
            if (evt_en && take)
               cnt_q <= last ? '0 : cnt_q + 1'b1;
         end
      end
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && !open_q) |-> !req_o);
   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> (cnt_q <= nbreq));
   assert_evt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |-> $past(take));
endmodule

// File: rtl/dreq_router.sv
module dreq_router
   import dreq_pkg::*;
#(
   parameter int unsigned NUM_CH      = 7,
   parameter int unsigned NUM_REQ     = 64,
   parameter int unsigned NUM_SYNC    = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter bit          SYNC_RESYNC = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [CFG_W-1:0]     reg_wdata,
   output logic [CFG_W-1:0]     reg_rdata,
   input  logic [NUM_REQ-1:0]   req_in,
   input  logic [NUM_SYNC-1:0]  sync_in,
   input  logic [NUM_CH-1:0]    dma_ack,
   output logic [NUM_CH-1:0]    dma_req,
   output logic [NUM_CH-1:0]    dma_evt,
   output logic                 irq
);
   if (NUM_REQ < 2 || NUM_REQ > (1 << SEL_W)) begin : g_chk_req
      $error("dreq_router: NUM_REQ out of range");
   end
   if (NUM_SYNC < 2 || NUM_SYNC > (1 << SS_W)) begin : g_chk_sync
      $error("dreq_router: NUM_SYNC out of range");
   end
   if ((1 << ADDR_W) <= ADDR_CLEAR) begin : g_chk_addr
      $error("dreq_router: ADDR_W too narrow for the clear address");
   end

   logic [NUM_CH-1:0][CFG_W-1:0] ctrl;
   logic [NUM_CH-1:0]            flags, ovr, oie;
   logic [NUM_SYNC-1:0]          sync_int;

   if (SYNC_RESYNC) begin : g_resync
      logic [NUM_SYNC-1:0] s1_q, s2_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
         end else begin
            s1_q <= sync_in;
            s2_q <= s1_q;
         end
      end
      assign sync_int = s2_q;
   end else begin : g_direct
      assign sync_int = sync_in;
   end

   dreq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .ovr_set (ovr),
      .ctrl_q  (ctrl),
      .flags_q (flags)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign oie[c] = ctrl[c][B_OIE];
      dreq_chan #(.NUM_REQ(NUM_REQ), .NUM_SYNC(NUM_SYNC)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .cfg_i  (ctrl[c]),
         .req_i  (req_in),
         .sync_i (sync_int),
         .ack_i  (dma_ack[c]),
         .req_o  (dma_req[c]),
         .evt_o  (dma_evt[c]),
         .ovr_o  (ovr[c])
      );
   end

   assign irq = |(flags & oie);

   assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flags != '0));
endmodule

// File: tb/dreq_router_bench.sv
module dreq_router_bench;
   localparam int NCH = 7;
   localparam logic [31:0] SE  = 32'h1 << 16;
   localparam logic [31:0] EGE = 32'h1 << 9;
   localparam logic [31:0] OIE = 32'h1 << 8;
   // vector: [15:8] channel, [7:0] request select
   localparam logic [15:0] ROUTE_VEC [0:5] = '{16'h0001, 16'h0107, 16'h023F,
                                               16'h0320, 16'h0411, 16'h062A};

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata, rv;
   logic [63:0] req_in = '0;
   logic [7:0]  sync_in = '0;
   logic [NCH-1:0] dma_ack = '0, dma_req, dma_evt;
   logic        irq;
   int          n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   dreq_router u_dreq_router (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
      .sync_in(sync_in), .dma_ack(dma_ack), .dma_req(dma_req),
      .dma_evt(dma_evt), .irq(irq)
   );

   function automatic logic [31:0] pol(int p); return 32'(p) << 17; endfunction
   function automatic logic [31:0] nb(int n);  return 32'(n) << 19; endfunction
   function automatic logic [31:0] ss(int s);  return 32'(s) << 24; endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 d = reg_rdata;
   endtask

   task automatic ack_one(input int c);
      @(negedge clk);
      dma_ack[c] = 1'b1;
      @(negedge clk);
      dma_ack[c] = 1'b0;
      #1;
   endtask

   task automatic step;
      @(negedge clk);
      #1;
   endtask

   initial begin
      #(8 * 100000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R11 reset state
      chk("R11 dma_req", 32'(dma_req), 0);
      chk("R11 dma_evt", 32'(dma_evt), 0);
      chk("R11 irq", 32'(irq), 0);
      rd(0, rv); chk("R11 ctrl0", rv, 0);
      rd(8, rv); chk("R11 status", rv, 0);
      rd(12, rv); chk("R12 unmapped", rv, 0);
      // R2 zero config blocks everything
      req_in = '1; #1;
      chk("R2 zero cfg", 32'(dma_req), 0);
      req_in = '0;

      // R1 routing table
      foreach (ROUTE_VEC[i]) begin
         int ch, sel;
         ch  = int'(ROUTE_VEC[i][15:8]);
         sel = int'(ROUTE_VEC[i][7:0]);
         wr(ch, 32'(sel));
         rd(ch, rv); chk("R12 ctrl readback", rv, 32'(sel));
         req_in = 64'd1 << sel; #1;
         chk("R1 route on", 32'(dma_req), 32'(1) << ch);
         req_in = ~(64'd1 << sel); #1;
         chk("R1 route off", 32'(dma_req), 0);
         req_in = '0;
         wr(ch, 0);
      end

      // R3/R5/R7 gated channel 0: sel 5, gate input 3, rising, N=2
      wr(0, nb(2) | 32'd5);
      wr(0, nb(2) | 32'd5 | SE | pol(1) | ss(3) | EGE);
      req_in[5] = 1'b1;
      step(); step();
      chk("R3 held without edge", 32'(dma_req[0]), 0);
      @(negedge clk); sync_in[3] = 1'b1;
      step();
      chk("R5 window open", 32'(dma_req[0]), 1);
      for (int i = 0; i < 3; i++) begin
         ack_one(0);
         chk("R5 window count", 32'(dma_req[0]), (i < 2) ? 1 : 0);
         chk("R7 event timing", 32'(dma_evt[0]), (i < 2) ? 0 : 1);
      end
      step();
      chk("R7 event one cycle", 32'(dma_evt[0]), 0);
      chk("R5 closed after count", 32'(dma_req[0]), 0);

      // R8 overrun, R10 irq, R9 clear
      @(negedge clk); sync_in[3] = 1'b0;
      step();
      chk("R4 falling ignored in rising mode", 32'(dma_req[0]), 0);
      @(negedge clk); sync_in[3] = 1'b1;
      @(negedge clk); sync_in[3] = 1'b0;
      @(negedge clk); sync_in[3] = 1'b1;
      rd(8, rv); chk("R8 overrun flag", rv, 1);
      chk("R8 window kept", 32'(dma_req[0]), 1);
      chk("R10 irq masked", 32'(irq), 0);
      wr(0, nb(2) | 32'd5 | SE | pol(1) | ss(3) | EGE | OIE);
      #1 chk("R10 irq enabled", 32'(irq), 1);
      wr(9, 32'h2);
      rd(8, rv); chk("R9 other bit no clear", rv, 1);
      wr(9, 32'h1);
      rd(8, rv); chk("R9 cleared", rv, 0);
      chk("R10 irq after clear", 32'(irq), 0);
      wr(0, 0);
      rd(0, rv); chk("R2 zero write", rv, 0);
      chk("R2 output off", 32'(dma_req[0]), 0);

      // R6 count lock
      wr(0, nb(2) | 32'd5);
      wr(0, nb(2) | 32'd5 | SE | pol(1) | ss(3));
      wr(0, nb(7) | 32'd5 | SE | pol(1) | ss(3));
      rd(0, rv); chk("R6 count locked", rv, nb(2) | 32'd5 | SE | pol(1) | ss(3));
      wr(0, 0);
      rd(0, rv); chk("R2 zero write clears count", rv, 0);
      req_in = '0; sync_in = '0;

      // R4 polarity, channel 1: sel 10, gate input 2, N=0
      wr(1, 32'd10 | SE | pol(2) | ss(2));
      req_in[10] = 1'b1;
      @(negedge clk); sync_in[2] = 1'b1;
      step(); chk("R4 falling mode ignores rise", 32'(dma_req[1]), 0);
      @(negedge clk); sync_in[2] = 1'b0;
      step(); chk("R4 falling mode opens", 32'(dma_req[1]), 1);
      ack_one(1); chk("R5 single request", 32'(dma_req[1]), 0);
      wr(1, 32'd10 | SE | pol(0) | ss(2));
      @(negedge clk); sync_in[2] = 1'b1;
      step(); chk("R4 none mode rise", 32'(dma_req[1]), 0);
      @(negedge clk); sync_in[2] = 1'b0;
      step(); chk("R4 none mode fall", 32'(dma_req[1]), 0);
      wr(1, 32'd10 | SE | pol(3) | ss(2));
      @(negedge clk); sync_in[2] = 1'b1;
      step(); chk("R4 both mode rise", 32'(dma_req[1]), 1);
      ack_one(1); chk("R4 both closed", 32'(dma_req[1]), 0);
      @(negedge clk); sync_in[2] = 1'b0;
      step(); chk("R4 both mode fall", 32'(dma_req[1]), 1);
      ack_one(1);
      wr(1, 0);
      req_in = '0;

      // R7 event in plain mode, channel 2: sel 20, N=1
      wr(2, nb(1) | 32'd20);
      wr(2, nb(1) | 32'd20 | EGE);
      req_in[20] = 1'b1; #1;
      chk("R1 plain with event", 32'(dma_req[2]), 1);
      ack_one(2); chk("R7 no event first ack", 32'(dma_evt[2]), 0);
      ack_one(2); chk("R7 event second ack", 32'(dma_evt[2]), 1);
      step(); chk("R7 event pulse ends", 32'(dma_evt[2]), 0);
      wr(2, 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule